// File: doc/BRIEF.md
# Hybrid Cellular Automaton Pattern Generator

This block is a one-dimensional linear cellular automaton register that serves as a pseudo-random stimulus source for built-in self-test. Every cell recomputes its bit on each enabled clock from three values only: its own bit and the bits of its two adjacent cells. A cell follows one of two linear rules. Under rule 90 the new bit is the XOR of the two neighbours. Under rule 150 the new bit is the XOR of both neighbours and the cell itself. A parameter fixes which rule each cell follows. Each cell draws only on its neighbours, so adjacent output bits avoid the shifted-copy correlation that a shift-register generator shows.

The end cells treat their missing outer neighbour as a constant 0. A seed can be loaded at any time. An all-zero seed is replaced by a nonzero substitute, because the zero state never leaves itself. The default five-cell rule vector is 150,150,90,90,90 for cells 0 to 4. The default breaks strict alternation on purpose. Both strictly alternating five-cell vectors are defective. Starting with rule 90 gives a singular map that can reach zero. Starting with rule 150 gives a map with a nonzero fixed state. The default vector has a primitive characteristic polynomial, x^5+x^3+x^2+x+1, so its period is 31.

Top module: `hca_pattern_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes RESET_SEED (default 5'b00001) after that edge.
- R2: On an advance step, a rule-90 cell takes the XOR of its left neighbour (cell i+1) and its right neighbour (cell i-1).
- R3: On an advance step, a rule-150 cell takes the XOR of its left neighbour, its own bit and its right neighbour.
- R4: The missing neighbour of cell 0 and of cell WIDTH-1 reads as 0 (null boundary).
- R5: Bit i of RULE_SEL selects the rule of cell i: 1 selects rule 150 and 0 selects rule 90. The default is 5'b00011, so cells 0 and 1 follow rule 150 and cells 2 to 4 follow rule 90. State bit i of `state_o` is cell i.
- R6: When `load_i` is high and `rst` is low, the state takes `seed_i` after the edge. A load takes priority over `en_i`.
- R7: A loaded seed of all zeros is replaced by ZERO_SUB (default 5'b00001).
- R8: When `rst`, `load_i` and `en_i` are all low, the state holds its value.
- R9: With the default rule vector, an enabled run from any nonzero state returns to that state after exactly 31 steps and never reaches the all-zero state.
- R10: `rst` takes priority over `load_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to RESET_SEED |
| en_i | input | 1 | Advance the automaton one step |
| load_i | input | 1 | Load the seed (after zero substitution) |
| seed_i | input | WIDTH | Seed value |
| state_o | output | WIDTH | Registered automaton state, bit i is cell i |

## Verification
The hardest condition to reach from the ports is the full-cycle condition. It needs a long uninterrupted enabled run that must come back to its start in exactly 31 steps, must not come back earlier, and must never pass through zero. The stimulus loads a one-hot seed, holds the enable high for the whole period and compares every intermediate state against the seed and against zero. Single-step checks load seeds whose ones sit on the end cells or on mixed-rule neighbours, so that each rule and each boundary shows up in one step.

// File: rtl/hca_pkg.sv
package hca_pkg;

  typedef enum logic {
    RULE_90  = 1'b0,
    RULE_150 = 1'b1
  } rule_e;

  function automatic logic ca_next(input rule_e rule, input logic lft,
                                   input logic self, input logic rgt);
    logic mix;
    mix = lft ^ rgt;
    if (rule == RULE_150) mix = mix ^ self;
    return mix;
  endfunction

endpackage

// File: rtl/hca_seed_fix.sv
module hca_seed_fix #(
  parameter int unsigned         WIDTH    = 5,
  parameter logic [WIDTH-1:0]    ZERO_SUB = WIDTH'(1)
) (
  input  logic [WIDTH-1:0] seed_i,
  output logic [WIDTH-1:0] seed_o
);

  logic is_zero;

  always_comb begin
    is_zero = (seed_i == '0);
    seed_o  = is_zero ? ZERO_SUB : seed_i;
  end

endmodule

// File: rtl/hca_cell.sv
module hca_cell
  import hca_pkg::*;
#(
  parameter rule_e RULE = RULE_90
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_val,
  input  logic load,
  input  logic load_val,
  input  logic step,
  input  logic lft_n,
  input  logic rgt_n,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= rst_val;
    else if (load) q <= load_val;
    else if (step) q <= ca_next(RULE, lft_n, q, rgt_n);
  end

  generate
    if (RULE == RULE_150) begin : g_r150
      a_r3_rule150_step: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (q == ($past(lft_n) ^ $past(q) ^ $past(rgt_n))));
    end else begin : g_r90
      a_r2_rule90_step: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (q == ($past(lft_n) ^ $past(rgt_n))));
    end
  endgenerate

endmodule

// File: rtl/hca_ca_array.sv
module hca_ca_array
  import hca_pkg::*;
#(
  parameter int unsigned      WIDTH      = 5,
  parameter logic [WIDTH-1:0] RULE_SEL   = WIDTH'(5'b00011),
  parameter logic [WIDTH-1:0] RESET_SEED = WIDTH'(1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] load_vec,
  input  logic             step,
  output logic [WIDTH-1:0] state
);

  localparam int unsigned EXT_W = WIDTH + 2;

  logic [EXT_W-1:0] ext;

  // null boundaries: a constant 0 on both ends
  assign ext = {1'b0, state, 1'b0};

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      localparam rule_e CELL_RULE = RULE_SEL[i] ? RULE_150 : RULE_90;
      hca_cell #(.RULE(CELL_RULE)) u_cell (
        .clk      (clk),
        .rst      (rst),
        .rst_val  (RESET_SEED[i]),
        .load     (load),
        .load_val (load_vec[i]),
        .step     (step),
        .lft_n    (ext[i+2]),
        .rgt_n    (ext[i]),
        .q        (state[i])
      );
    end
  endgenerate

  // R4: the two end cells see 0 from outside
  a_r4_low_edge: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (state[0] == ($past(state[1]) ^
                         (RULE_SEL[0] ? $past(state[0]) : 1'b0))));

endmodule

// File: rtl/hca_pattern_gen.sv
module hca_pattern_gen #(
  parameter int unsigned      WIDTH      = 5,
  parameter logic [WIDTH-1:0] RULE_SEL   = WIDTH'(5'b00011),
  parameter logic [WIDTH-1:0] RESET_SEED = WIDTH'(1),
  parameter logic [WIDTH-1:0] ZERO_SUB   = WIDTH'(1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] seed_i,
  output logic [WIDTH-1:0] state_o
);

  logic [WIDTH-1:0] seed_ok;
  logic [WIDTH-1:0] ca_state;

  hca_seed_fix #(.WIDTH(WIDTH), .ZERO_SUB(ZERO_SUB)) u_seed_fix (
    .seed_i (seed_i),
    .seed_o (seed_ok)
  );

  hca_ca_array #(
    .WIDTH      (WIDTH),
    .RULE_SEL   (RULE_SEL),
    .RESET_SEED (RESET_SEED)
  ) u_array (
    .clk      (clk),
    .rst      (rst),
    .load     (load_i),
    .load_vec (seed_ok),
    .step     (en_i),
    .state    (ca_state)
  );

  assign state_o = ca_state;

  a_r6_load_capture: assert property (@(posedge clk) disable iff (rst)
    (load_i && (seed_i != '0)) |=> (state_o == $past(seed_i)));

  a_r7_zero_seed_sub: assert property (@(posedge clk) disable iff (rst)
    (load_i && (seed_i == '0)) |=> (state_o == ZERO_SUB));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !en_i) |=> $stable(state_o));

  a_r9_never_zero: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (state_o != '0));

endmodule

// File: tb/test_hca_pattern_gen.sv
module test_hca_pattern_gen;

  localparam int W = 5;

  logic         clk = 1'b0;
  logic         rst;
  logic         en_i;
  logic         load_i;
  logic [W-1:0] seed_i;
  logic [W-1:0] state_o;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  hca_pattern_gen i_hca_pattern_gen (
    .clk     (clk),
    .rst     (rst),
    .en_i    (en_i),
    .load_i  (load_i),
    .seed_i  (seed_i),
    .state_o (state_o)
  );

  // {seed, state after one step}; default rules: cells 0,1 rule 150, cells 2..4 rule 90
  localparam logic [9:0] STEP_TAB [7] = '{
    {5'b00001, 5'b00011},   // R3 R4 low end cell
    {5'b10000, 5'b01000},   // R2 R4 high end cell
    {5'b00100, 5'b01010},   // R2 R3
    {5'b11111, 5'b10010},   // R2 R3 R5
    {5'b01010, 5'b10011},   // R2 R3 R5
    {5'b00010, 5'b00111},   // R3 R5
    {5'b01000, 5'b10100}    // R2 R4
  };

  task automatic check(input string tag, input logic [W-1:0] got,
                       input logic [W-1:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; en_i = 1'b0; load_i = 1'b0; seed_i = '0;
    tick(); tick();
    rst = 1'b0;
    check("R1 reset state", state_o, 5'b00001);

    foreach (STEP_TAB[k]) begin
      load_i = 1'b1; seed_i = STEP_TAB[k][9:5];
      tick();
      load_i = 1'b0; en_i = 1'b1;
      tick();
      en_i = 1'b0;
      check("R2 R3 R4 R5 single step", state_o, STEP_TAB[k][4:0]);
    end

    // R8 hold
    begin
      logic [W-1:0] held;
      held = state_o;
      tick(); tick(); tick();
      check("R8 hold with enable low", state_o, held);
    end

    // R7 zero seed
    load_i = 1'b1; seed_i = 5'b00000;
    tick();
    load_i = 1'b0;
    check("R7 zero seed substituted", state_o, 5'b00001);

    // R6 load over enable
    load_i = 1'b1; en_i = 1'b1; seed_i = 5'b10110;
    tick();
    load_i = 1'b0; en_i = 1'b0;
    check("R6 load priority over enable", state_o, 5'b10110);

    // R10 reset over load
    rst = 1'b1; load_i = 1'b1; seed_i = 5'b11001;
    tick();
    rst = 1'b0; load_i = 1'b0;
    check("R10 reset priority over load", state_o, 5'b00001);

    // R9 full period from a one-hot seed
    begin
      int early = 0;
      int zeros = 0;
      load_i = 1'b1; seed_i = 5'b00100;
      tick();
      load_i = 1'b0; en_i = 1'b1;
      for (int s = 1; s <= 31; s++) begin
        tick();
        if (state_o == 5'b00000) zeros++;
        if (s < 31 && state_o == 5'b00100) early++;
        if (s == 31) begin
          en_i = 1'b0;
          check("R9 return after 31 steps", state_o, 5'b00100);
        end
      end
      check("R9 no early return", W'(early), 5'd0);
      check("R9 zero state never seen", W'(zeros), 5'd0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule